// File: doc/BRIEF.md
# Memory-Side Request Arbiter

This block picks which request leaves a cache controller toward memory next. Three sources compete for the slot. The first is a queue of outstanding misses. The second is a queue of dirty-line writes. The third is a speculative prefetch source. Every queue entry presents the following to the arbiter:

- a pending flag
- a byte address
- a length in lines
- an allocation order number

A separate flag says that ready response packets are waiting. Those responses take the slot ahead of every request.

The normal preference is a miss over a write. When the write queue is full and none of its entries is in service, the arbiter drains writes instead. Conflicting addresses are ordered so that stale data cannot escape. A write that overlaps the miss about to go out is sent first. A miss that overlaps the write about to be drained, and was allocated earlier than that write, is sent first. A prefetch is used only when nothing else is pending and the miss queue can still take an entry.

The choice leaves the block on a valid/ready grant channel.

- Once `gnt_valid` rises, source, index and address stay fixed until `gnt_ready` is seen high at a clock edge. A refused send therefore simply waits.
- The edge on which valid and ready are both high is the acceptance. On that edge the owning queue marks the entry in service.
- Acceptance leaves the channel empty for one cycle, so that the queues can update their pending flags before the next choice is made.

Top module: `mwarb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt_valid` is low.
- R2: If `rsp_pend` is high while no grant is held, the next grant has source code 0 (response), index 0 and address 0, whatever else is pending.
- R3: If only one of the two queues has pending entries, the grant goes to that queue's oldest pending entry. Source code 1 means miss and 2 means write. Age is judged by serial-number comparison of the ORD_W-bit order numbers: a is older than b when bit ORD_W-1 of (a - b) is set, so order 14 is older than order 1 for ORD_W = 4.
- R4: If both queues have pending entries, the write queue is not in drain mode, and no pending write overlaps the oldest pending miss, the grant goes to that miss.
- R5: Overlap is tested on line addresses, which are the byte address with its low OFF_W bits dropped. An entry with line L and length field n covers lines L to L+n. While the write queue is not full, a pending write that overlaps the oldest pending miss is granted before that miss, the oldest such write first. Ranges that only touch, such as lines 8–9 against line 10, do not overlap.
- R6: Drain mode holds when `wq_full` is high and `wq_busy` is 0. In drain mode the oldest pending write is granted. The exception is a pending miss that overlaps that write and has an older order number: in that case the oldest such miss is granted instead.
- R7: When the write queue is full but `wq_busy` is nonzero, a pending miss is granted ahead of pending writes, even if they overlap it.
- R8: With no response, no pending miss and no pending write, `pf_valid` produces a grant with source code 3, index 0 and address `pf_addr`, but only when `mq_full` is low. When `mq_full` is high the prefetch is never granted.
- R9: A grant is held with unchanged source, index and address until it is accepted. The cycle after acceptance has `gnt_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_pend | input | 1 | Response packets are ready to go out |
| mq_pend | input | MQ_N | Miss entries waiting to be issued |
| mq_addr | input | MQ_N*ADDR_W | Miss entry byte addresses, entry i at bits i*ADDR_W |
| mq_len | input | MQ_N*LEN_W | Miss entry length in lines minus one |
| mq_ord | input | MQ_N*ORD_W | Miss entry allocation order numbers |
| mq_full | input | 1 | Miss queue has no free slot |
| wq_pend | input | WQ_N | Write entries waiting to be issued |
| wq_addr | input | WQ_N*ADDR_W | Write entry byte addresses |
| wq_len | input | WQ_N*LEN_W | Write entry length in lines minus one |
| wq_ord | input | WQ_N*ORD_W | Write entry allocation order numbers |
| wq_full | input | 1 | Write queue has no free slot |
| wq_busy | input | CNT_W | Number of write entries in service |
| pf_valid | input | 1 | Prefetch request available |
| pf_addr | input | ADDR_W | Prefetch byte address |
| gnt_valid | output | 1 | Grant held on the channel |
| gnt_ready | input | 1 | Bus accepts the grant this cycle |
| gnt_src | output | 2 | Granted source: 0 response, 1 miss, 2 write, 3 prefetch |
| gnt_idx | output | IDX_W | Granted queue entry |
| gnt_addr | output | ADDR_W | Granted byte address |

## Verification
A choice is registered, so `gnt_valid` and the grant fields appear after the first rising edge that sees the stimulus. The bench drives inputs just after a rising edge and reads the channel at the following falling edge. Acceptance removes the grant at the next rising edge. The stimulus is therefore cleared in the cycle after acceptance, which is what a queue marking its entry in service would do. The empty cycle that follows is checked at the next falling edge. Stall tests hold ready low across several falling edges and check that the grant does not move. Blocked-prefetch tests confirm over three falling edges that nothing appears.

// File: rtl/mwarb_pkg.sv
`timescale 1ns/1ps
package mwarb_pkg;
  typedef enum logic [1:0] {
    SRC_RESP  = 2'd0,
    SRC_MISS  = 2'd1,
    SRC_WRITE = 2'd2,
    SRC_PREF  = 2'd3
  } src_e;
endpackage

// File: rtl/mwarb_oldest.sv
`timescale 1ns/1ps
module mwarb_oldest #(
  parameter int N     = 4,
  parameter int ORD_W = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]       cand,
  input  logic [N*ORD_W-1:0] ord,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  function automatic logic older(input logic [ORD_W-1:0] a, input logic [ORD_W-1:0] b);
    logic [ORD_W-1:0] d;
    d = a - b;
    return d[ORD_W-1];
  endfunction

  logic [ORD_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || older(ord[i*ORD_W +: ORD_W], best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = ord[i*ORD_W +: ORD_W];
      end
    end
  end
endmodule

// File: rtl/mwarb_conflict.sv
`timescale 1ns/1ps
module mwarb_conflict #(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int LEN_W  = 2,
  parameter int ORD_W  = 4
) (
  input  logic [N-1:0]        pend,
  input  logic [N*LINE_W-1:0] line,
  input  logic [N*LEN_W-1:0]  len,
  input  logic [N*ORD_W-1:0]  ord,
  input  logic [LINE_W-1:0]   ref_line,
  input  logic [LEN_W-1:0]    ref_len,
  input  logic [ORD_W-1:0]    ref_ord,
  input  logic                use_ord,
  output logic [N-1:0]        hit
);
  localparam int EW = LINE_W + 1;

  logic [EW-1:0] ref_lo, ref_hi;
  assign ref_lo = {1'b0, ref_line};
  assign ref_hi = ref_lo + EW'(ref_len) + EW'(1);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [EW-1:0]    lo, hi;
    logic [ORD_W-1:0] diff;
    logic             ovl, earlier;
    assign lo      = {1'b0, line[i*LINE_W +: LINE_W]};
    assign hi      = lo + EW'(len[i*LEN_W +: LEN_W]) + EW'(1);
    assign ovl     = (lo < ref_hi) && (ref_lo < hi);
    assign diff    = ord[i*ORD_W +: ORD_W] - ref_ord;
    assign earlier = diff[ORD_W-1];
    assign hit[i]  = pend[i] && ovl && (!use_ord || earlier);
  end
endmodule

// File: rtl/mwarb.sv
`timescale 1ns/1ps
module mwarb
  import mwarb_pkg::*;
#(
  parameter int MQ_N   = 4,
  parameter int WQ_N   = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LEN_W  = 2,
  parameter int ORD_W  = 4,
  localparam int IDX_W = $clog2(MQ_N > WQ_N ? MQ_N : WQ_N),
  localparam int CNT_W = $clog2(WQ_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rsp_pend,
  input  logic [MQ_N-1:0]        mq_pend,
  input  logic [MQ_N*ADDR_W-1:0] mq_addr,
  input  logic [MQ_N*LEN_W-1:0]  mq_len,
  input  logic [MQ_N*ORD_W-1:0]  mq_ord,
  input  logic                   mq_full,
  input  logic [WQ_N-1:0]        wq_pend,
  input  logic [WQ_N*ADDR_W-1:0] wq_addr,
  input  logic [WQ_N*LEN_W-1:0]  wq_len,
  input  logic [WQ_N*ORD_W-1:0]  wq_ord,
  input  logic                   wq_full,
  input  logic [CNT_W-1:0]       wq_busy,
  input  logic                   pf_valid,
  input  logic [ADDR_W-1:0]      pf_addr,
  output logic                   gnt_valid,
  input  logic                   gnt_ready,
  output logic [1:0]             gnt_src,
  output logic [IDX_W-1:0]       gnt_idx,
  output logic [ADDR_W-1:0]      gnt_addr
);
  localparam int LINE_W = ADDR_W - OFF_W;

  // line addresses
  logic [MQ_N*LINE_W-1:0] m_line;
  logic [WQ_N*LINE_W-1:0] w_line;
  for (genvar i = 0; i < MQ_N; i++) begin : g_mline
    assign m_line[i*LINE_W +: LINE_W] = mq_addr[i*ADDR_W+OFF_W +: LINE_W];
  end
  for (genvar i = 0; i < WQ_N; i++) begin : g_wline
    assign w_line[i*LINE_W +: LINE_W] = wq_addr[i*ADDR_W+OFF_W +: LINE_W];
  end

  // oldest entry of each queue
  logic             m_any, w_any;
  logic [IDX_W-1:0] m_idx, w_idx;

  mwarb_oldest #(.N(MQ_N), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_mold (
    .cand(mq_pend), .ord(mq_ord), .found(m_any), .idx(m_idx));
  mwarb_oldest #(.N(WQ_N), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_wold (
    .cand(wq_pend), .ord(wq_ord), .found(w_any), .idx(w_idx));

  // writes overlapping the oldest miss
  logic [WQ_N-1:0]  w_hit;
  logic             wc_found;
  logic [IDX_W-1:0] wc_idx;

  mwarb_conflict #(.N(WQ_N), .LINE_W(LINE_W), .LEN_W(LEN_W), .ORD_W(ORD_W)) u_wscan (
    .pend(wq_pend), .line(w_line), .len(wq_len), .ord(wq_ord),
    .ref_line(m_line[m_idx*LINE_W +: LINE_W]),
    .ref_len(mq_len[m_idx*LEN_W +: LEN_W]),
    .ref_ord(mq_ord[m_idx*ORD_W +: ORD_W]),
    .use_ord(1'b0), .hit(w_hit));
  mwarb_oldest #(.N(WQ_N), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_wpick (
    .cand(w_hit), .ord(wq_ord), .found(wc_found), .idx(wc_idx));

  // earlier misses overlapping the oldest write
  logic [MQ_N-1:0]  m_hit;
  logic             mc_found;
  logic [IDX_W-1:0] mc_idx;

  mwarb_conflict #(.N(MQ_N), .LINE_W(LINE_W), .LEN_W(LEN_W), .ORD_W(ORD_W)) u_mscan (
    .pend(mq_pend), .line(m_line), .len(mq_len), .ord(mq_ord),
    .ref_line(w_line[w_idx*LINE_W +: LINE_W]),
    .ref_len(wq_len[w_idx*LEN_W +: LEN_W]),
    .ref_ord(wq_ord[w_idx*ORD_W +: ORD_W]),
    .use_ord(1'b1), .hit(m_hit));
  mwarb_oldest #(.N(MQ_N), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_mpick (
    .cand(m_hit), .ord(mq_ord), .found(mc_found), .idx(mc_idx));

  // next choice
  logic             drain;
  logic             nxt_v;
  src_e             nxt_s;
  logic [IDX_W-1:0] nxt_i;
  logic [ADDR_W-1:0] nxt_a;

  assign drain = wq_full && (wq_busy == '0);

  always_comb begin
    nxt_v = 1'b0;
    nxt_s = SRC_RESP;
    nxt_i = '0;
    if (rsp_pend) begin
      nxt_v = 1'b1;
    end else if (m_any && w_any) begin
      nxt_v = 1'b1;
      if (drain) begin
        if (mc_found) begin nxt_s = SRC_MISS;  nxt_i = mc_idx; end
        else          begin nxt_s = SRC_WRITE; nxt_i = w_idx;  end
      end else if (!wq_full && wc_found) begin
        nxt_s = SRC_WRITE; nxt_i = wc_idx;
      end else begin
        nxt_s = SRC_MISS;  nxt_i = m_idx;
      end
    end else if (m_any) begin
      nxt_v = 1'b1; nxt_s = SRC_MISS;  nxt_i = m_idx;
    end else if (w_any) begin
      nxt_v = 1'b1; nxt_s = SRC_WRITE; nxt_i = w_idx;
    end else if (pf_valid && !mq_full) begin
      nxt_v = 1'b1; nxt_s = SRC_PREF;
    end
  end

  always_comb begin
    case (nxt_s)
      SRC_MISS:  nxt_a = mq_addr[nxt_i*ADDR_W +: ADDR_W];
      SRC_WRITE: nxt_a = wq_addr[nxt_i*ADDR_W +: ADDR_W];
      SRC_PREF:  nxt_a = pf_addr;
      default:   nxt_a = '0;
    endcase
  end

  // grant register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_src   <= SRC_RESP;
      gnt_idx   <= '0;
      gnt_addr  <= '0;
    end else if (gnt_valid) begin
      if (gnt_ready) gnt_valid <= 1'b0;
    end else if (nxt_v) begin
      gnt_valid <= 1'b1;
      gnt_src   <= nxt_s;
      gnt_idx   <= nxt_i;
      gnt_addr  <= nxt_a;
    end
  end
endmodule

// File: rtl/mwarb_chk.sv
`timescale 1ns/1ps
module mwarb_chk
  import mwarb_pkg::*;
#(
  parameter int MQ_N   = 4,
  parameter int WQ_N   = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_pend,
  input logic [MQ_N-1:0]   mq_pend,
  input logic              mq_full,
  input logic [WQ_N-1:0]   wq_pend,
  input logic              pf_valid,
  input logic              gnt_valid,
  input logic              gnt_ready,
  input logic [1:0]        gnt_src,
  input logic [IDX_W-1:0]  gnt_idx,
  input logic [ADDR_W-1:0] gnt_addr
);
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_src) && $stable(gnt_idx) && $stable(gnt_addr)); // R9
  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid); // R9
  AST_RESP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && rsp_pend |=> gnt_valid && gnt_src == SRC_RESP); // R2
  AST_PF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && mq_full |=> !(gnt_valid && gnt_src == SRC_PREF)); // R8
  AST_PF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && !rsp_pend && mq_pend == '0 && wq_pend == '0 && pf_valid && !mq_full
    |=> gnt_valid && gnt_src == SRC_PREF); // R8
  AST_NO_PHANTOM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && mq_pend == '0 |=> !(gnt_valid && gnt_src == SRC_MISS)); // R3
  AST_NO_PHANTOM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && wq_pend == '0 |=> !(gnt_valid && gnt_src == SRC_WRITE)); // R3
  AST_MISS_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_src == SRC_MISS |-> 32'(gnt_idx) < MQ_N); // R3
endmodule

bind mwarb mwarb_chk #(.MQ_N(MQ_N), .WQ_N(WQ_N), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_pend(rsp_pend), .mq_pend(mq_pend), .mq_full(mq_full),
  .wq_pend(wq_pend), .pf_valid(pf_valid), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_src(gnt_src), .gnt_idx(gnt_idx), .gnt_addr(gnt_addr));

// File: tb/mwarb_tb.sv
`timescale 1ns/1ps
module mwarb_tb;
  localparam int N = 4, AW = 32, LW = 2, OW = 4, IW = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic rsp_pend, mq_full, wq_full, pf_valid, gnt_ready, gnt_valid;
  logic [N-1:0] mq_pend, wq_pend;
  logic [N*AW-1:0] mq_addr, wq_addr;
  logic [N*LW-1:0] mq_len, wq_len;
  logic [N*OW-1:0] mq_ord, wq_ord;
  logic [CW-1:0] wq_busy;
  logic [AW-1:0] pf_addr, gnt_addr;
  logic [1:0] gnt_src;
  logic [IW-1:0] gnt_idx;

  logic [AW-1:0] ma[N], wa[N];
  logic [LW-1:0] ml[N], wl[N];
  logic [OW-1:0] mo[N], wo[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mq_addr[i*AW +: AW] = ma[i]; mq_len[i*LW +: LW] = ml[i]; mq_ord[i*OW +: OW] = mo[i];
      wq_addr[i*AW +: AW] = wa[i]; wq_len[i*LW +: LW] = wl[i]; wq_ord[i*OW +: OW] = wo[i];
    end
  end

  mwarb u_dut (
    .clk(clk), .rst_n(rst_n), .rsp_pend(rsp_pend),
    .mq_pend(mq_pend), .mq_addr(mq_addr), .mq_len(mq_len), .mq_ord(mq_ord), .mq_full(mq_full),
    .wq_pend(wq_pend), .wq_addr(wq_addr), .wq_len(wq_len), .wq_ord(wq_ord), .wq_full(wq_full),
    .wq_busy(wq_busy), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_src(gnt_src), .gnt_idx(gnt_idx),
    .gnt_addr(gnt_addr));

  typedef struct packed { logic [1:0] src; logic [IW-1:0] idx; logic [AW-1:0] addr; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [AW-1:0] ln(input int l);
    return AW'(l) << 6;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  // monitor: compares each accepted grant with the scoreboard
  always @(negedge clk) begin
    if (rst_n && gnt_valid && gnt_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", $sformatf("src=%0d idx=%0d addr=%h", gnt_src, gnt_idx, gnt_addr), "no grant");
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(gnt_src == e.src && gnt_idx == e.idx && gnt_addr == e.addr, t,
              $sformatf("src=%0d idx=%0d addr=%h", gnt_src, gnt_idx, gnt_addr),
              $sformatf("src=%0d idx=%0d addr=%h", e.src, e.idx, e.addr));
      end
    end
  end

  task automatic idle();
    rsp_pend = 0; mq_full = 0; wq_full = 0; pf_valid = 0; pf_addr = '0;
    mq_pend = '0; wq_pend = '0; wq_busy = '0;
    for (int i = 0; i < N; i++) begin
      ma[i] = '0; wa[i] = '0; ml[i] = '0; wl[i] = '0; mo[i] = '0; wo[i] = '0;
    end
  endtask

  // driver: stimulus already set; push expectation, wait for acceptance, clear
  task automatic go(input logic [1:0] s, input int i, input logic [AW-1:0] a, input string t);
    exp_q.push_back('{src: s, idx: IW'(i), addr: a});
    tag_q.push_back(t);
    @(posedge clk); @(posedge clk); #2 idle();
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 20000);
    check(1'b0, "watchdog", "timeout", "finish");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    gnt_ready = 1'b1;
    rsp_pend = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt_valid == 1'b0, "R1", $sformatf("%0d", gnt_valid), "0");
    @(posedge clk); #2 rst_n = 1'b1; rsp_pend = 1'b0;
    @(negedge clk);
    check(gnt_valid == 1'b0, "R1", $sformatf("%0d", gnt_valid), "0");
    @(posedge clk); #2;

    // R2: response beats a pending miss
    rsp_pend = 1; mq_pend = 4'b0001; ma[0] = ln(4);
    go(2'd0, 0, '0, "R2");

    // R3: oldest miss
    mq_pend = 4'b0101; ma[0] = ln(7); mo[0] = 5; ma[2] = ln(9); mo[2] = 3;
    go(2'd1, 2, ln(9), "R3");
    // R3: wrapped order numbers, 14 older than 1
    mq_pend = 4'b1010; ma[1] = ln(3); mo[1] = 14; ma[3] = ln(5); mo[3] = 1;
    go(2'd1, 1, ln(3), "R3");
    // R3: writes only
    wq_pend = 4'b1001; wa[0] = ln(11); wo[0] = 6; wa[3] = ln(12); wo[3] = 4;
    go(2'd2, 3, ln(12), "R3");

    // R4: both pending, no overlap
    mq_pend = 4'b0010; ma[1] = ln(10); mo[1] = 7; wq_pend = 4'b0100; wa[2] = ln(30); wo[2] = 2;
    go(2'd1, 1, ln(10), "R4");

    // R5: write covering lines 9-10 overlaps miss at 10
    mq_pend = 4'b0001; ma[0] = ln(10); mo[0] = 3; wq_pend = 4'b0010; wa[1] = ln(9); wl[1] = 1; wo[1] = 8;
    go(2'd2, 1, ln(9), "R5");
    // R5: lines 8-9 only touch line 10
    mq_pend = 4'b0001; ma[0] = ln(10); mo[0] = 3; wq_pend = 4'b0010; wa[1] = ln(8); wl[1] = 1; wo[1] = 8;
    go(2'd1, 0, ln(10), "R5");

    // R6: drain, no conflicting miss
    wq_full = 1; wq_pend = 4'b0101; wa[0] = ln(40); wo[0] = 9; wa[2] = ln(41); wo[2] = 5;
    mq_pend = 4'b1000; ma[3] = ln(50); mo[3] = 1;
    go(2'd2, 2, ln(41), "R6");
    // R6: earlier overlapping miss goes first, not the oldest miss
    wq_full = 1; wq_pend = 4'b0100; wa[2] = ln(41); wo[2] = 5;
    mq_pend = 4'b0011; ma[0] = ln(60); mo[0] = 0; ma[1] = ln(41); mo[1] = 2;
    go(2'd1, 1, ln(41), "R6");
    // R6: overlapping miss is younger, write goes
    wq_full = 1; wq_pend = 4'b0100; wa[2] = ln(41); wo[2] = 5;
    mq_pend = 4'b0010; ma[1] = ln(41); mo[1] = 7;
    go(2'd2, 2, ln(41), "R6");

    // R7: full with entries in service, miss preferred despite overlap
    wq_full = 1; wq_busy = 1; wq_pend = 4'b0010; wa[1] = ln(10); wo[1] = 1;
    mq_pend = 4'b0001; ma[0] = ln(10); mo[0] = 3;
    go(2'd1, 0, ln(10), "R7");

    // R8: prefetch taken when idle
    pf_valid = 1; pf_addr = 32'h0000_1234;
    go(2'd3, 0, 32'h0000_1234, "R8");
    // R8: prefetch blocked by full miss queue
    pf_valid = 1; pf_addr = 32'h0000_5678; mq_full = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(gnt_valid == 1'b0, "R8", $sformatf("%0d", gnt_valid), "0");
    end
    @(posedge clk); #2 idle();
    // R8: a pending miss outranks the prefetch
    pf_valid = 1; pf_addr = 32'h0000_9ab0; mq_pend = 4'b0100; ma[2] = ln(5); mo[2] = 0;
    go(2'd1, 2, ln(5), "R8");

    // R9: stall holds the grant; acceptance leaves one empty cycle
    gnt_ready = 0; wq_pend = 4'b0010; wa[1] = ln(20); wo[1] = 2;
    @(posedge clk); #2 rsp_pend = 1; mq_pend = 4'b0001; ma[0] = ln(3);
    @(negedge clk);
    check(gnt_valid && gnt_src == 2'd2 && gnt_idx == 1 && gnt_addr == ln(20), "R9",
          $sformatf("v=%0d src=%0d idx=%0d", gnt_valid, gnt_src, gnt_idx), "v=1 src=2 idx=1");
    @(posedge clk); @(negedge clk);
    check(gnt_valid && gnt_src == 2'd2 && gnt_idx == 1 && gnt_addr == ln(20), "R9",
          $sformatf("v=%0d src=%0d idx=%0d", gnt_valid, gnt_src, gnt_idx), "v=1 src=2 idx=1");
    exp_q.push_back('{src: 2'd2, idx: IW'(1), addr: ln(20)}); tag_q.push_back("R9");
    exp_q.push_back('{src: 2'd0, idx: IW'(0), addr: '0});     tag_q.push_back("R2");
    @(posedge clk); #2 gnt_ready = 1; wq_pend = '0;
    @(posedge clk); @(negedge clk);
    check(gnt_valid == 1'b0, "R9", $sformatf("%0d", gnt_valid), "0");
    @(posedge clk); @(posedge clk); #2 idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9", $sformatf("%0d left", exp_q.size()), "0 left");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule